// File: doc/BRIEF.md
# Floating-Point Exception Event and Interrupt Controller

This peripheral collects six exception pulses from a floating-point unit (invalid operation, divide by zero, overflow, underflow, inexact result and denormal input). It holds each one in its own sticky event register and combines them into a single level interrupt. Software reaches the block over a simple 32-bit register bus with separate read and write strobes. Through that bus it reads and clears the events and manages a six-bit interrupt enable mask.

The mask has three views. A direct view replaces the whole mask on a write. A set view turns on the mask bits written as 1. A clear view turns off the mask bits written as 1. All three views read back the current mask. Clearing an event register here has no effect on the status flags held inside the processor, which software clears on its own.

Each event class is handled by a small two-state machine, `EV_CLEAR` and `EV_LATCHED`. The transition `EV_CLEAR -> EV_LATCHED` is taken on a rising edge of the class's exception input, or on a software write of 1. The transition `EV_LATCHED -> EV_CLEAR` is taken on a software write of 0, but only when no rising edge arrives in the same cycle. Read data and the interrupt are registered.

Top module: `fpexc_irq_ctrl`

## Requirements
- R1: After reset, every event register and the mask read 0x00000000 and `irq_o` is 0.
- R2: A rising edge on `exc_i[k]` latches event k, which reads as 0x00000001 at offset 0x100 + 4*k. Classes 0 to 5 are, in order: invalid operation, divide by zero, overflow, underflow, inexact and denormal input. Bits 31:1 of an event register read 0.
- R3: A write to an event register loads wdata bit 0 into that event: 0 clears it and 1 sets it.
- R4: When a rising edge on `exc_i[k]` and a write of 0 to event k occur in the same cycle, the event ends up at 1.
- R5: An input that is held high latches one event only. If software clears that event while the input is still high, it stays 0 until the input falls and rises again.
- R6: A write to offset 0x300 replaces the mask with wdata bits 5:0, where bit k enables class k. A read of 0x300 returns the mask, with bits 31:6 reading 0.
- R7: A write to offset 0x304 sets each mask bit whose wdata bit is 1 and leaves the other bits unchanged. A read of 0x304 returns the mask.
- R8: A write to offset 0x308 clears each mask bit whose wdata bit is 1 and leaves the other bits unchanged. A read of 0x308 returns the mask.
- R9: `irq_o` is a registered OR, over all classes, of (event AND enable). It changes one clock after the event or mask change that causes it.
- R10: A read of any unmapped or misaligned offset returns 0. A write to such an offset changes no event and no mask bit.
- R11: `bus_rdata_o` presents the addressed word in the cycle after the edge that samples `bus_rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_i | input | NUM_EXC | Exception inputs from the floating-point unit, one per class |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Each event state machine can be left in the wrong state. A stuck `EV_LATCHED` shows up on the next read of that event as 1 after a clear. A missed transition shows as a 0 after a pulse. Either error also reaches `irq_o` one clock later whenever that class is enabled. A wrong mask is seen on the next read of any of its three views, and on `irq_o` one cycle after the mask write. So every state fault reaches a port within two clocks of the stimulus that exposes it.

// File: rtl/fpexc_pkg.sv
package fpexc_pkg;

    localparam int unsigned EXC_CLASSES = 6;

    // Per-class event state
    typedef enum logic {
        EV_CLEAR   = 1'b0,
        EV_LATCHED = 1'b1
    } ev_state_e;

    // Mask update selected by the bus decoder
    typedef enum logic [1:0] {
        MASK_HOLD = 2'd0,
        MASK_LOAD = 2'd1,
        MASK_SET  = 2'd2,
        MASK_CLR  = 2'd3
    } mask_op_e;

endpackage

// File: rtl/fpexc_event_cell.sv
module fpexc_event_cell
    import fpexc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic exc_i,
    input  logic sw_wr_i,
    input  logic sw_val_i,
    output logic evt_o
);

    logic      exc_q;
    logic      rise;
    ev_state_e st_q;
    ev_state_e st_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            exc_q <= 1'b0;
        end else begin
            exc_q <= exc_i;
        end
    end

    assign rise = exc_i & ~exc_q;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= EV_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: a hardware edge outranks a software clear
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EV_CLEAR: begin
                if (rise || (sw_wr_i && sw_val_i)) begin
                    st_d = EV_LATCHED;
                end
            end
            EV_LATCHED: begin
                if (!rise && sw_wr_i && !sw_val_i) begin
                    st_d = EV_CLEAR;
                end
            end
        endcase
    end

    // Output
    always_comb begin
        evt_o = (st_q == EV_LATCHED);
    end

endmodule

// File: rtl/fpexc_mask_reg.sv
module fpexc_mask_reg
    import fpexc_pkg::*;
#(
    parameter int unsigned WIDTH = EXC_CLASSES
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  mask_op_e         op_i,
    input  logic [WIDTH-1:0] wbits_i,
    output logic [WIDTH-1:0] mask_o
);

    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        unique case (op_i)
            MASK_HOLD: mask_d = mask_q;
            MASK_LOAD: mask_d = wbits_i;
            MASK_SET:  mask_d = mask_q | wbits_i;
            MASK_CLR:  mask_d = mask_q & ~wbits_i;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/fpexc_bus_decode.sv
module fpexc_bus_decode
    import fpexc_pkg::*;
#(
    parameter int unsigned NUM_EXC   = EXC_CLASSES,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned EVT_BASE  = 32'h100,
    parameter int unsigned MASK_BASE = 32'h300
) (
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_EXC-1:0] evt_i,
    input  logic [NUM_EXC-1:0] mask_i,
    output logic [NUM_EXC-1:0] evt_wr_o,
    output mask_op_e           mask_op_o,
    output logic [DATA_W-1:0]  rd_word_o
);

    localparam logic [ADDR_W-1:0] OFS_LOAD = ADDR_W'(MASK_BASE);
    localparam logic [ADDR_W-1:0] OFS_SET  = ADDR_W'(MASK_BASE + 4);
    localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(MASK_BASE + 8);

    logic [NUM_EXC-1:0] evt_hit;
    logic               mask_hit;

    for (genvar k = 0; k < NUM_EXC; k++) begin : g_evt_hit
        assign evt_hit[k] = (addr_i == ADDR_W'(EVT_BASE + 4 * k));
    end

    assign mask_hit = (addr_i == OFS_LOAD) || (addr_i == OFS_SET) || (addr_i == OFS_CLR);
    assign evt_wr_o = wr_i ? evt_hit : '0;

    always_comb begin
        mask_op_o = MASK_HOLD;
        if (wr_i) begin
            if (addr_i == OFS_LOAD) begin
                mask_op_o = MASK_LOAD;
            end else if (addr_i == OFS_SET) begin
                mask_op_o = MASK_SET;
            end else if (addr_i == OFS_CLR) begin
                mask_op_o = MASK_CLR;
            end
        end
    end

    always_comb begin
        rd_word_o = '0;
        for (int k = 0; k < NUM_EXC; k++) begin
            if (evt_hit[k]) begin
                rd_word_o[0] = evt_i[k];
            end
        end
        if (mask_hit) begin
            rd_word_o[NUM_EXC-1:0] = mask_i;
        end
    end

endmodule

// File: rtl/fpexc_irq_ctrl.sv
module fpexc_irq_ctrl
    import fpexc_pkg::*;
#(
    parameter int unsigned NUM_EXC   = EXC_CLASSES,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned EVT_BASE  = 32'h100,
    parameter int unsigned MASK_BASE = 32'h300
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EXC-1:0] exc_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o
);

    logic [NUM_EXC-1:0] evt_vec;
    logic [NUM_EXC-1:0] mask_vec;
    logic [NUM_EXC-1:0] evt_wr;
    mask_op_e           mask_op;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  rdata_q;
    logic               irq_q;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata_i[DATA_W-1:NUM_EXC];

    fpexc_bus_decode #(
        .NUM_EXC  (NUM_EXC),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .EVT_BASE (EVT_BASE),
        .MASK_BASE(MASK_BASE)
    ) decode_i (
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .evt_i    (evt_vec),
        .mask_i   (mask_vec),
        .evt_wr_o (evt_wr),
        .mask_op_o(mask_op),
        .rd_word_o(rd_word)
    );

    for (genvar k = 0; k < NUM_EXC; k++) begin : g_evt
        fpexc_event_cell cell_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .exc_i   (exc_i[k]),
            .sw_wr_i (evt_wr[k]),
            .sw_val_i(bus_wdata_i[0]),
            .evt_o   (evt_vec[k])
        );
    end

    fpexc_mask_reg #(
        .WIDTH(NUM_EXC)
    ) mask_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .op_i   (mask_op),
        .wbits_i(bus_wdata_i[NUM_EXC-1:0]),
        .mask_o (mask_vec)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            rdata_q <= bus_rd_i ? rd_word : '0;
            irq_q   <= |(evt_vec & mask_vec);
        end
    end

    assign bus_rdata_o = rdata_q;
    assign irq_o       = irq_q;

endmodule

// File: rtl/fpexc_irq_ctrl_chk.sv
module fpexc_irq_ctrl_chk #(
    parameter int unsigned NUM_EXC   = 6,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned EVT_BASE  = 32'h100,
    parameter int unsigned MASK_BASE = 32'h300
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_EXC-1:0] exc_i,
    input logic               bus_wr_i,
    input logic               bus_rd_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [DATA_W-1:0]  bus_wdata_i,
    input logic [DATA_W-1:0]  bus_rdata_o,
    input logic               irq_o,
    input logic [NUM_EXC-1:0] evt_vec,
    input logic [NUM_EXC-1:0] mask_vec
);

    logic mapped;

    always_comb begin
        mapped = (bus_addr_i == ADDR_W'(MASK_BASE))
              || (bus_addr_i == ADDR_W'(MASK_BASE + 4))
              || (bus_addr_i == ADDR_W'(MASK_BASE + 8));
        for (int k = 0; k < NUM_EXC; k++) begin
            if (bus_addr_i == ADDR_W'(EVT_BASE + 4 * k)) begin
                mapped = 1'b1;
            end
        end
    end

    AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> irq_o == |($past(evt_vec) & $past(mask_vec))); // R9

    AST_MASK_SET_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == ADDR_W'(MASK_BASE + 4))
        |=> (mask_vec & $past(bus_wdata_i[NUM_EXC-1:0])) == $past(bus_wdata_i[NUM_EXC-1:0])); // R7

    AST_MASK_CLR_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == ADDR_W'(MASK_BASE + 8))
        |=> (mask_vec & $past(bus_wdata_i[NUM_EXC-1:0])) == '0); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && !mapped) |=> bus_rdata_o == '0); // R10

    AST_UNMAPPED_WR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && !mapped) |=> $stable(mask_vec)); // R10

    for (genvar k = 0; k < NUM_EXC; k++) begin : g_evt_chk
        AST_EDGE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (exc_i[k] && !$past(exc_i[k])) |=> evt_vec[k]); // R4

        AST_SW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_wr_i && bus_addr_i == ADDR_W'(EVT_BASE + 4 * k) && !bus_wdata_i[0]
             && !(exc_i[k] && !$past(exc_i[k]))) |=> !evt_vec[k]); // R3
    end

endmodule

bind fpexc_irq_ctrl fpexc_irq_ctrl_chk #(
    .NUM_EXC  (NUM_EXC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .EVT_BASE (EVT_BASE),
    .MASK_BASE(MASK_BASE)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exc_i      (exc_i),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o),
    .evt_vec    (evt_vec),
    .mask_vec   (mask_vec)
);

// File: tb/fpexc_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpexc_irq_ctrl_tb_top;

    localparam int NX = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NX-1:0] exc = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    logic [NX-1:0] m_evt = '0;
    logic [NX-1:0] m_mask = '0;

    int checks = 0;
    int fails = 0;
    logic rd_pend = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    fpexc_irq_ctrl dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .exc_i      (exc),
        .bus_wr_i   (wr),
        .bus_rd_i   (rd),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    // Monitor: compare read data the cycle after the strobe is sampled (R11)
    always @(posedge clk) rd_pend <= rd;

    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata=%08h expected=%08h", t, rdata, e);
            end
        end
    end

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string t);
        rd = 1'b1;
        addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        wr = 1'b1;
        addr = a;
        wdata = d;
        if (a == 12'h300) m_mask = d[NX-1:0];
        if (a == 12'h304) m_mask = m_mask | d[NX-1:0];
        if (a == 12'h308) m_mask = m_mask & ~d[NX-1:0];
        for (int k = 0; k < NX; k++) begin
            if (a == 12'h100 + 12'(4 * k)) m_evt[k] = d[0];
        end
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse(input int k);
        exc[k] = 1'b1;
        m_evt[k] = 1'b1;
        @(negedge clk);
        exc[k] = 1'b0;
    endtask

    task automatic irq_now(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq=%0b expected=%0b", t, irq, e);
        end
    endtask

    task automatic irq_chk(input string t);
        @(negedge clk);
        irq_now(|(m_evt & m_mask), t);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int k = 0; k < NX; k++) rd_chk(12'h100 + 12'(4 * k), 32'h0, "R1 event reset");
        rd_chk(12'h300, 32'h0, "R1 mask reset");
        irq_now(1'b0, "R1 irq reset");

        // R2 each class latches at its own offset
        for (int k = 0; k < NX; k++) begin
            pulse(k);
            rd_chk(12'h100 + 12'(4 * k), 32'h1, "R2 event latched");
        end
        irq_chk("R9 irq masked off");

        // R6 direct mask view, upper bits ignored
        wr_reg(12'h300, 32'hFFFF_FFC5);
        rd_chk(12'h300, 32'h05, "R6 mask load");
        rd_chk(12'h304, 32'h05, "R7 set view reads mask");
        rd_chk(12'h308, 32'h05, "R8 clear view reads mask");
        irq_chk("R9 irq enabled events");

        // R3 software clear
        wr_reg(12'h100, 32'h0);
        wr_reg(12'h108, 32'hFFFF_FFFE);
        rd_chk(12'h100, 32'h0, "R3 clear class 0");
        rd_chk(12'h108, 32'h0, "R3 clear class 2");
        irq_chk("R9 irq after clears");

        // R7 set view
        wr_reg(12'h304, 32'h0A);
        rd_chk(12'h300, 32'h0F, "R7 set view merge");
        irq_chk("R9 irq after set");

        // R8 clear view
        wr_reg(12'h308, 32'h03);
        rd_chk(12'h300, 32'h0C, "R8 clear view");
        irq_chk("R9 irq after clear view");

        // R9 exact latency: clear class 3, irq drops one clock later
        wr_reg(12'h10C, 32'h0);
        irq_now(1'b1, "R9 irq not yet dropped");
        irq_chk("R9 irq dropped");

        // R3 software set
        wr_reg(12'h114, 32'h1);
        rd_chk(12'h114, 32'h1, "R3 software set");

        // R5 held input latches once
        wr_reg(12'h110, 32'h0);
        exc[4] = 1'b1;
        m_evt[4] = 1'b1;
        repeat (2) @(negedge clk);
        wr_reg(12'h110, 32'h0);
        repeat (2) @(negedge clk);
        rd_chk(12'h110, 32'h0, "R5 held input no relatch");
        exc[4] = 1'b0;
        @(negedge clk);
        pulse(4);
        rd_chk(12'h110, 32'h1, "R5 new edge latches");

        // R4 edge and clear in the same cycle
        wr_reg(12'h104, 32'h0);
        exc[1] = 1'b1;
        wr_reg(12'h104, 32'h0);
        m_evt[1] = 1'b1;
        exc[1] = 1'b0;
        rd_chk(12'h104, 32'h1, "R4 hardware set wins");

        // R10 unmapped accesses
        wr_reg(12'h118, 32'h1);
        wr_reg(12'h30C, 32'hFF);
        wr_reg(12'h0FC, 32'h1);
        wr_reg(12'h102, 32'h0);
        wr_reg(12'h301, 32'h0);
        rd_chk(12'h118, 32'h0, "R10 unmapped read 0x118");
        rd_chk(12'h30C, 32'h0, "R10 unmapped read 0x30C");
        rd_chk(12'h102, 32'h0, "R10 misaligned read");
        rd_chk(12'h300, {26'h0, m_mask}, "R10 mask untouched");
        rd_chk(12'h100, {31'h0, m_evt[0]}, "R10 class 0 untouched");
        rd_chk(12'h114, {31'h0, m_evt[5]}, "R10 class 5 untouched");
        irq_chk("R9 irq final");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule